// File: doc/BRIEF.md
# Time-Base Tap Interval Timer

This block turns a free-running 64-bit time base into two periodic event sources, a fixed-interval timer and a watchdog. Each timer watches one bit of the time base, its "tap". An event fires when that bit goes from 0 to 1, so a tap at bit position N gives one event every 2^N time-base ticks. When an event fires, a sticky status bit is set. Each interrupt output is that status bit gated by its enable bit in the control register.

Software sees two 32-bit registers through one write port: a control word and a status word. The control word picks the tap for each timer and holds the interrupt enables. A parameter picks one of two ways to turn the control fields into a bit position. In table mode, a 2-bit period field indexes a four-entry table of bit positions. In extended mode, a 4-bit extension field joins the 2-bit period field to form a 6-bit code, and the bit position is 63 minus that code. Status bits are cleared by writing 1 to them. A write of 0 leaves a status bit as it is.

Top module: `tbtap_timer`

## Requirements
- R1: A write with `wr_sel`=0 stores all 32 bits of `wr_data` into the control word, and the control word appears on `ctl_q` one cycle later.
- R2: A write with `wr_sel`=1 clears every status bit where `wr_data` holds 1 and leaves the other status bits unchanged.
- R3: `fit_irq` is status bit 26 AND control bit 23, and `wdg_irq` is status bit 30 AND control bit 27. Both follow a register write in the cycle after the write.
- R4: An event fires only when the selected tap is 0 at one clock edge and 1 at the next. A tap that stays high or falls produces no event.
- R5: In table mode, control bits 25:24 pick entry k of `FIT_TAPS` for the fixed-interval tap, and control bits 31:30 pick entry k of `WDG_TAPS` for the watchdog tap. Entry k occupies bits 6k+5:6k. The defaults are {9,13,17,21} and {29,33,37,41}.
- R6: A fixed-interval event sets status bit 26, and a watchdog event sets status bit 30. The bit is visible one cycle after the clock edge that samples the rising tap.
- R7: If an event and a status clear of the same bit happen in the same cycle, the bit ends up set.
- R8: After reset the control word and the status word are zero, and both interrupts are low.
- R9: A change of tap selection never produces an event by itself. The first cycle on a new tap only records the value of that tap.
- R10: In extended mode, the tap position is 63 minus {ext, period}. For the fixed-interval timer, ext is control bits 16:13 and period is bits 25:24. For the watchdog, ext is bits 20:17 and period is bits 31:30.
- R11: Status bits other than 30 and 26 always read as zero, and no status write can set any bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_val | input | 64 | Free-running time base |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 status |
| wr_data | input | 32 | Write data |
| ctl_q | output | 32 | Control word |
| sts_q | output | 32 | Status word |
| fit_irq | output | 1 | Fixed-interval interrupt level |
| wdg_irq | output | 1 | Watchdog interrupt level |

## Verification
Some cases are hard to reach by letting the time base run: edges on high taps such as bit 63, and a tap change made while the old tap and the new tap hold different values. The bench drives the time-base port directly, so it can jump straight to patterns that toggle exactly the bits it wants. It starts a tap change with the old tap low and the new tap high, which is the case where a naive edge detector would fire falsely. It also lines up a rising tap with a status clear of the same bit in a single cycle. A second instance built in extended mode covers the bit-0 and bit-63 taps.

// File: rtl/tbtap_timer.sv
module tbtap_timer #(
  parameter bit          EXT_MODE = 1'b0,
  parameter logic [23:0] FIT_TAPS = {6'd21, 6'd17, 6'd13, 6'd9},
  parameter logic [23:0] WDG_TAPS = {6'd41, 6'd37, 6'd33, 6'd29}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] tb_val,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] ctl_q,
  output logic [31:0] sts_q,
  output logic        fit_irq,
  output logic        wdg_irq
);
  localparam int TW    = 6;
  localparam int NT    = 2;
  localparam int FIS_B = 26;
  localparam int WIS_B = 30;
  localparam int FIE_B = 23;
  localparam int WIE_B = 27;

  logic [NT-1:0][1:0]    per;
  logic [NT-1:0][3:0]    ext;
  logic [NT-1:0][23:0]   tab;
  logic [NT-1:0][TW-1:0] tap_sel;
  logic [NT-1:0]         tap_bit;
  logic [NT-1:0]         evt;
  logic                  fis, wis;

  assign per = {ctl_q[31:30], ctl_q[25:24]};
  assign ext = {ctl_q[20:17], ctl_q[16:13]};
  assign tab = {WDG_TAPS, FIT_TAPS};

  for (genvar g = 0; g < NT; g++) begin : chan
    logic [TW-1:0] ext_pos, tab_pos, last_sel;
    logic          last_bit, armed;

    assign ext_pos    = 6'd63 - {ext[g], per[g]};
    assign tab_pos    = tab[g][per[g]*TW +: TW];
    assign tap_sel[g] = EXT_MODE ? ext_pos : tab_pos;
    assign tap_bit[g] = tb_val[tap_sel[g]];
    assign evt[g]     = armed && (last_sel == tap_sel[g]) && tap_bit[g] && !last_bit;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        last_sel <= '0;
        last_bit <= 1'b0;
        armed    <= 1'b0;
      end else begin
        last_sel <= tap_sel[g];
        last_bit <= tap_bit[g];
        armed    <= 1'b1;
      end
    end
  end

  wire sts_wr = wr_en && wr_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      fis   <= 1'b0;
      wis   <= 1'b0;
    end else begin
      if (wr_en && !wr_sel) ctl_q <= wr_data;
      fis <= evt[0] || (fis && !(sts_wr && wr_data[FIS_B]));
      wis <= evt[1] || (wis && !(sts_wr && wr_data[WIS_B]));
    end
  end

  assign sts_q   = {1'b0, wis, 3'b000, fis, 26'd0};
  assign fit_irq = sts_q[FIS_B] && ctl_q[FIE_B];
  assign wdg_irq = sts_q[WIS_B] && ctl_q[WIE_B];
endmodule

// File: rtl/tbtap_timer_chk.sv
module tbtap_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [31:0] wr_data,
  input logic [31:0] ctl_q,
  input logic [31:0] sts_q,
  input logic [1:0]  evt,
  input logic [5:0]  tap_sel0,
  input logic        tap_bit0
);
  a_r1_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (ctl_q == $past(wr_data)));
  a_r2_fit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && wr_data[26] && !evt[0]) |=> !sts_q[26]);
  a_r2_wdg_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && wr_data[30] && !evt[1]) |=> !sts_q[30]);
  a_r7_fit_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |=> sts_q[26]);
  a_r6_wdg_set: assert property (@(posedge clk) disable iff (!rst_n)
    evt[1] |=> sts_q[30]);
  a_r11_fit_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[26]) |-> $past(evt[0]));
  a_r4_rising_only: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |-> (tap_bit0 && !$past(tap_bit0)));
  a_r9_no_edge_on_reselect: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_sel0 != $past(tap_sel0)) |-> !evt[0]);
  a_r8_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctl_q == 32'd0 && sts_q == 32'd0));
endmodule

bind tbtap_timer tbtap_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .ctl_q(ctl_q), .sts_q(sts_q), .evt(evt), .tap_sel0(tap_sel[0]), .tap_bit0(tap_bit[0])
);

// File: tb/tbtap_timer_tb_top.sv
`timescale 1ns/1ps
module tbtap_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tb_val = '0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctl_q, sts_q, ctl_x, sts_x;
  logic        fit_irq, wdg_irq, fit_x, wdg_x;

  always #2 clk = ~clk;

  tbtap_timer dut_i (.clk(clk), .rst_n(rst_n), .tb_val(tb_val), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .ctl_q(ctl_q), .sts_q(sts_q),
    .fit_irq(fit_irq), .wdg_irq(wdg_irq));

  tbtap_timer #(.EXT_MODE(1'b1)) dut_x (.clk(clk), .rst_n(rst_n), .tb_val(tb_val),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ctl_q(ctl_x), .sts_q(sts_x),
    .fit_irq(fit_x), .wdg_irq(wdg_x));

  typedef struct {
    bit          x;
    logic [31:0] ctl, sts;
    logic        fit, wdg;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_err = 0;
  logic [31:0] model_ctl = '0;

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [63:0] tb, input bit we, input bit ws, input logic [31:0] d,
                      input bit chk, input bit x, input logic [31:0] es,
                      input logic ef, input logic ew, input string tag);
    exp_t e;
    @(negedge clk);
    tb_val = tb; wr_en = we; wr_sel = ws; wr_data = d;
    if (we && !ws) model_ctl = d;
    if (chk) begin
      e.x = x; e.ctl = model_ctl; e.sts = es; e.fit = ef; e.wdg = ew; e.tag = tag;
      sb.push_back(e);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        cmp(e.tag, "ctl", e.x ? ctl_x : ctl_q, e.ctl);
        cmp(e.tag, "sts", e.x ? sts_x : sts_q, e.sts);
        cmp(e.tag, "fit_irq", {31'd0, e.x ? fit_x : fit_irq}, {31'd0, e.fit});
        cmp(e.tag, "wdg_irq", {31'd0, e.x ? wdg_x : wdg_irq}, {31'd0, e.wdg});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // table mode, default instance
    step(64'h0, 0, 0, 0, 1, 0, 32'h0, 0, 0, "R8 reset state");
    step(64'h0, 1, 0, 32'h0880_0000, 1, 0, 32'h0, 0, 0, "R1 control write");
    step(64'h0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    step(64'h200, 0, 0, 0, 1, 0, 32'h0400_0000, 1, 0, "R6 fit tap 9 rise");
    step(64'h200, 0, 0, 0, 1, 0, 32'h0400_0000, 1, 0, "R4 tap held high");
    step(64'h3FF, 1, 1, 32'h0400_0000, 1, 0, 32'h0, 0, 0, "R2 clear fit status");
    step(64'h400, 0, 0, 0, 1, 0, 32'h0, 0, 0, "R4 falling tap no event");
    step(64'h600, 0, 0, 0, 1, 0, 32'h0400_0000, 1, 0, "R4 second rise");
    step(64'h600, 1, 1, 32'hBBFF_FFFF, 1, 0, 32'h0400_0000, 1, 0, "R2 R11 zero bits keep, no set");
    step(64'h600, 1, 0, 32'h0800_0000, 1, 0, 32'h0400_0000, 0, 0, "R3 fit enable off masks irq");
    step(64'h2000_0600, 0, 0, 0, 1, 0, 32'h4400_0000, 0, 1, "R6 wdg tap 29 rise");
    step(64'h0000_0600, 1, 1, 32'h4000_0000, 1, 0, 32'h0400_0000, 0, 0, "R3 wdg irq follows clear");
    step(64'h2000_0600, 1, 1, 32'h4000_0000, 1, 0, 32'h4400_0000, 0, 1, "R7 set beats clear");
    step(64'h2000_2000, 1, 1, 32'hFFFF_FFFF, 1, 0, 32'h0, 0, 0, "R2 clear all");
    step(64'h2000_2000, 1, 0, 32'h0980_0000, 1, 0, 32'h0, 0, 0, "R1 select fit entry 1");
    step(64'h2000_2000, 0, 0, 0, 1, 0, 32'h0, 0, 0, "R9 reselect no false edge");
    step(64'h2000_2200, 0, 0, 0, 1, 0, 32'h0, 0, 0, "R5 old tap 9 ignored");
    step(64'h2000_0000, 0, 0, 0, 1, 0, 32'h0, 0, 0, "R4 tap 13 falls");
    step(64'h2000_2000, 0, 0, 0, 1, 0, 32'h0400_0000, 1, 0, "R5 tap 13 rise");
    // extended mode instance
    step(64'h0, 1, 1, 32'hFFFF_FFFF, 1, 0, 32'h0, 0, 0, "R2 clear before ext phase");
    step(64'h0, 1, 0, 32'h0B81_E000, 1, 1, 32'h0, 0, 0, "R10 ext control write");
    step(64'h0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    step(64'h1, 0, 0, 0, 1, 1, 32'h0400_0000, 1, 0, "R10 ext fit tap bit 0");
    step(64'h8000_0000_0000_0001, 0, 0, 0, 1, 1, 32'h4400_0000, 1, 1, "R10 ext wdg tap bit 63");
    step(64'h8000_0000_0020_0001, 0, 0, 0, 1, 0, 32'h0400_0000, 1, 0, "R5 table entry 3 tap 21");
    step(64'h8000_0000_0020_0001, 0, 0, 0, 0, 0, 0, 0, 0, "");
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule